// File: doc/BRIEF.md
# Timer Compare Output Unit

This block holds a free-running up-counter and a programmable compare value of the same width. On every clock it checks whether the two are equal. On the first cycle of a match it acts according to a 4-bit mode register. The possible actions are: set an output latch, clear it, only raise a sticky interrupt flag, or act as a period register. In the last case the counter restarts from zero and a one-cycle conversion-start strobe is emitted. The counter advances only when its clock enable is high. It has a sticky overflow flag that records natural wrap-around only.

Software loads the compare value and the mode through a write-only port with one address bit. The output latch reaches the pin only while the output-enable control is high. An asynchronous active-low reset is released to the logic through a two-stage synchronizer, so the block leaves reset two clock edges after the reset input rises.

Top module: `tcmp_unit`

## Requirements
- R1: After reset the counter, compare value, mode, output latch, interrupt flag, overflow flag and strobe all read zero.
- R2: A write with `wr_addr`=0 loads the full `wr_data` word as the compare value. A write with `wr_addr`=1 loads the mode from `wr_data[3:0]`, and upper data bits have no effect on the mode.
- R3: The counter adds one on each clock where `tick_en` is high and holds otherwise. The overflow flag is set only when the counter steps from all ones to zero, and it stays set until `ovf_clr` is pulsed.
- R4: A match exists when the counter equals the compare value. It is acted on only in its first cycle, and the results appear at the next clock edge. A match that persists because the counter is stopped causes no further action until equality is lost and regained.
- R5: Mode 4'b1000 sets the output latch to 1 on a match. Mode 4'b1001 clears it to 0 on a match.
- R6: Mode 4'b1010 and mode 4'b1011 leave the output latch unchanged on a match.
- R7: Any match in modes 4'b1000 to 4'b1011 sets the interrupt flag. The flag holds until `irq_clr` is pulsed, and a match in the same cycle as the clear wins.
- R8: Mode 4'b0000 and every other encoding outside 4'b1000 to 4'b1011 force the output latch to 0 at the next clock edge. They produce no interrupt and no strobe.
- R9: In mode 4'b1011 a match resets the counter to zero at the next edge and pulses `conv_start_o` for exactly one cycle. With `tick_en` held high the strobe period is the compare value plus one cycles.
- R10: A counter reset caused by mode 4'b1011 never sets the overflow flag, even when the compare value is all ones.
- R11: `pin_o` equals the output latch while `oe_ctl` is high and is 0 while it is low. `pin_oe_o` follows `oe_ctl`, and the latch value is not changed by `oe_ctl`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Counter clock enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects compare value, 1 selects mode |
| wr_data | input | TW (16) | Write data |
| irq_clr | input | 1 | Clears the interrupt flag |
| ovf_clr | input | 1 | Clears the overflow flag |
| oe_ctl | input | 1 | Output-enable control for the pin |
| count_o | output | TW (16) | Current counter value |
| ovf_o | output | 1 | Sticky overflow flag |
| latch_o | output | 1 | Output latch value |
| pin_o | output | 1 | Pin data, latch gated by output enable |
| pin_oe_o | output | 1 | Pin output enable |
| irq_o | output | 1 | Sticky match interrupt flag |
| conv_start_o | output | 1 | One-cycle conversion-start strobe |

## Verification
Every registered result depends on the cycle in which the counter equals the compare value. The latch, the interrupt flag, the strobe and the counter restart all appear one clock edge after that cycle. A register write takes effect one edge after it is presented. A mode change to an inactive encoding clears the latch one edge later still. The bench drives inputs and samples outputs at falling edges. It keeps its own arithmetic model of the counter, stepping it once per enabled cycle and restarting it in the cycle after equality. Each check is placed at the falling edge that follows the rising edge where the result is due. This also applies to the two full wrap-arounds, which are checked at the exact count of 65535 and 65536 ticks.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;

  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    MODE_OFF  = 4'b0000,
    MODE_SET  = 4'b1000,
    MODE_CLR  = 4'b1001,
    MODE_IRQ  = 4'b1010,
    MODE_TRIG = 4'b1011
  } cmp_mode_e;

  // Decoded view of the mode register; every field is one wire to the action logic.
  typedef struct packed {
    logic active;    // a compare mode: matches raise the interrupt
    logic drive_hi;  // match sets the latch
    logic drive_lo;  // match clears the latch
    logic trig;      // match restarts the counter and strobes conversion
  } mode_dec_t;

  function automatic mode_dec_t decode_mode(input logic [MODE_W-1:0] raw);
    mode_dec_t d;
    d = '0;
    case (raw)
      MODE_SET:  begin d.active = 1'b1; d.drive_hi = 1'b1; end
      MODE_CLR:  begin d.active = 1'b1; d.drive_lo = 1'b1; end
      MODE_IRQ:  begin d.active = 1'b1; end
      MODE_TRIG: begin d.active = 1'b1; d.trig = 1'b1; end
      default:   d = '0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/tcmp_rst_sync.sv
module tcmp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;

  // Assertion is asynchronous; release ripples through STAGES flops.
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/tcmp_timer.sv
module tcmp_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          sync_clr,
  input  logic          ovf_clr,
  output logic [TW-1:0] count_o,
  output logic          ovf_o
);

  localparam logic [TW-1:0] ONE = {{(TW-1){1'b0}}, 1'b1};
  localparam logic [TW-1:0] TOP = '1;

  logic [TW-1:0] cnt_q, cnt_d;
  logic          ovf_q, ovf_d;

  always_comb begin
    cnt_d = cnt_q;
    ovf_d = ovf_q;
    if (ovf_clr) ovf_d = 1'b0;
    if (sync_clr) begin
      // Restart from the compare trigger: not a wrap, flag untouched.
      cnt_d = '0;
    end else if (tick_en) begin
      cnt_d = cnt_q + ONE;
      if (cnt_q == TOP) ovf_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  assign count_o = cnt_q;
  assign ovf_o   = ovf_q;

endmodule

// File: rtl/tcmp_match.sv
module tcmp_match #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] count_i,
  input  logic [TW-1:0] cmp_i,
  output logic          hit_o
);

  logic eq;
  logic eq_q;

  assign eq = (count_i == cmp_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eq_q <= 1'b0;
    else        eq_q <= eq;
  end

  // Only the first cycle of equality counts as a match event.
  assign hit_o = eq & ~eq_q;

endmodule

// File: rtl/tcmp_action.sv
module tcmp_action
  import tcmp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      hit_i,
  input  mode_dec_t dec_i,
  input  logic      irq_clr,
  output logic      latch_o,
  output logic      irq_o,
  output logic      strobe_o,
  output logic      trig_clr_o
);

  logic latch_q, latch_d;
  logic irq_q, irq_d;
  logic stb_q, stb_d;

  always_comb begin
    latch_d = latch_q;
    irq_d   = irq_q;
    stb_d   = 1'b0;
    if (irq_clr) irq_d = 1'b0;
    if (!dec_i.active) begin
      latch_d = 1'b0;
    end else if (hit_i) begin
      irq_d = 1'b1;
      if (dec_i.drive_hi) latch_d = 1'b1;
      if (dec_i.drive_lo) latch_d = 1'b0;
      if (dec_i.trig)     stb_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= 1'b0;
      irq_q   <= 1'b0;
      stb_q   <= 1'b0;
    end else begin
      latch_q <= latch_d;
      irq_q   <= irq_d;
      stb_q   <= stb_d;
    end
  end

  assign trig_clr_o = hit_i & dec_i.trig;
  assign latch_o    = latch_q;
  assign irq_o      = irq_q;
  assign strobe_o   = stb_q;

endmodule

// File: rtl/tcmp_unit.sv
module tcmp_unit
  import tcmp_pkg::*;
#(
  parameter int TW        = 16,
  parameter int RST_STAGE = 2
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          tick_en,
  input  logic          wr_en,
  input  logic          wr_addr,
  input  logic [TW-1:0] wr_data,
  input  logic          irq_clr,
  input  logic          ovf_clr,
  input  logic          oe_ctl,
  output logic [TW-1:0] count_o,
  output logic          ovf_o,
  output logic          latch_o,
  output logic          pin_o,
  output logic          pin_oe_o,
  output logic          irq_o,
  output logic          conv_start_o
);

  logic              rst_q;
  logic [TW-1:0]     cmp_q, cmp_d;
  logic [MODE_W-1:0] mode_q, mode_d;
  mode_dec_t         dec;
  logic              hit;
  logic              trig_clr;

  tcmp_rst_sync #(.STAGES(RST_STAGE)) u_rst (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_q)
  );

  // Write-only register file: compare value and mode.
  always_comb begin
    cmp_d  = cmp_q;
    mode_d = mode_q;
    if (wr_en) begin
      if (!wr_addr) cmp_d  = wr_data;
      else          mode_d = wr_data[MODE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      cmp_q  <= '0;
      mode_q <= MODE_OFF;
    end else begin
      cmp_q  <= cmp_d;
      mode_q <= mode_d;
    end
  end

  assign dec = decode_mode(mode_q);

  tcmp_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_q),
    .tick_en  (tick_en),
    .sync_clr (trig_clr),
    .ovf_clr  (ovf_clr),
    .count_o  (count_o),
    .ovf_o    (ovf_o)
  );

  tcmp_match #(.TW(TW)) u_match (
    .clk     (clk),
    .rst_n   (rst_q),
    .count_i (count_o),
    .cmp_i   (cmp_q),
    .hit_o   (hit)
  );

  tcmp_action u_act (
    .clk        (clk),
    .rst_n      (rst_q),
    .hit_i      (hit),
    .dec_i      (dec),
    .irq_clr    (irq_clr),
    .latch_o    (latch_o),
    .irq_o      (irq_o),
    .strobe_o   (conv_start_o),
    .trig_clr_o (trig_clr)
  );

  assign pin_oe_o = oe_ctl;
  assign pin_o    = latch_o & oe_ctl;

endmodule

// File: rtl/tcmp_unit_chk.sv
module tcmp_unit_chk #(
  parameter int TW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick_en,
  input logic          irq_clr,
  input logic [3:0]    mode,
  input logic [TW-1:0] count,
  input logic          ovf,
  input logic          latch,
  input logic          irq,
  input logic          strobe
);

  assert_strobe_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe);

  assert_trig_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> (count == '0));

  assert_trig_no_ovf_R10: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> !$rose(ovf));

  assert_ovf_on_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> (count == '0 && $past(count) == '1));

  assert_hold_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> (count == $past(count) || strobe));

  assert_irq_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);

  assert_inactive_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[3:2] != 2'b10) |=> !latch);

endmodule

bind tcmp_unit tcmp_unit_chk #(.TW(TW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_q),
  .tick_en (tick_en),
  .irq_clr (irq_clr),
  .mode    (mode_q),
  .count   (count_o),
  .ovf     (ovf_o),
  .latch   (latch_o),
  .irq     (irq_o),
  .strobe  (conv_start_o)
);

// File: tb/sim_tcmp_unit.sv
`timescale 1ns/1ps
module sim_tcmp_unit;

  logic        clk;
  logic        arst_n;
  logic        tick_en;
  logic        wr_en;
  logic        wr_addr;
  logic [15:0] wr_data;
  logic        irq_clr;
  logic        ovf_clr;
  logic        oe_ctl;
  logic [15:0] count_o;
  logic        ovf_o;
  logic        latch_o;
  logic        pin_o;
  logic        pin_oe_o;
  logic        irq_o;
  logic        conv_start_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  tcmp_unit u0 (
    .clk (clk), .arst_n (arst_n), .tick_en (tick_en), .wr_en (wr_en),
    .wr_addr (wr_addr), .wr_data (wr_data), .irq_clr (irq_clr),
    .ovf_clr (ovf_clr), .oe_ctl (oe_ctl), .count_o (count_o),
    .ovf_o (ovf_o), .latch_o (latch_o), .pin_o (pin_o),
    .pin_oe_o (pin_oe_o), .irq_o (irq_o), .conv_start_o (conv_start_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    arst_n = 1'b0; tick_en = 1'b0; wr_en = 1'b0; wr_addr = 1'b0;
    wr_data = '0; irq_clr = 1'b0; ovf_clr = 1'b0; oe_ctl = 1'b0;
    step(2);
    arst_n = 1'b1;
    step(3);
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step(1);
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1: reset state
    do_reset();
    chk("R1 count", count_o, 0);
    chk("R1 ovf", ovf_o, 0);
    chk("R1 latch", latch_o, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 strobe", conv_start_o, 0);

    // Sweep all 16 mode encodings from a latch that is set.
    for (int m = 0; m < 16; m++) begin
      bit valid;
      int strobes;
      logic exp_latch;
      valid = (m >= 8 && m <= 11);
      do_reset();
      oe_ctl = 1'b1;
      wr(1'b0, 16'd3);
      wr(1'b1, 16'h0008);
      tick_en = 1'b1;
      step(4);
      tick_en = 1'b0;
      chk("R5 set on match", latch_o, 1);
      chk("R7 irq on match", irq_o, 1);
      irq_clr = 1'b1; step(1); irq_clr = 1'b0;
      chk("R7 irq cleared", irq_o, 0);
      wr(1'b1, 16'(m));
      step(1);
      chk("R8 latch after mode write", latch_o, valid ? 1 : 0);
      wr(1'b0, 16'd10);
      tick_en = 1'b1;
      strobes = 0;
      for (int k = 0; k < 8; k++) begin
        step(1);
        if (conv_start_o) strobes++;
      end
      tick_en = 1'b0;
      exp_latch = (m == 8 || m == 10 || m == 11);
      chk(m == 9 ? "R5 clear on match" : (valid ? "R6 latch kept" : "R8 latch low"),
          latch_o, exp_latch);
      chk(valid ? "R7 irq by mode" : "R8 no irq", irq_o, valid ? 1 : 0);
      chk(m == 11 ? "R9 one strobe" : "R8 no strobe", strobes, m == 11 ? 1 : 0);
      chk(m == 11 ? "R9 restart count" : "R3 count", count_o, m == 11 ? 1 : 12);
      chk("R11 pin follows latch", pin_o, exp_latch);
      oe_ctl = 1'b0; step(1);
      chk("R11 pin gated", pin_o, 0);
      chk("R11 oe out", pin_oe_o, 0);
      chk("R11 latch kept", latch_o, exp_latch);
    end

    // R9 / R4: exact cycle model of the period mode, compare value 4.
    begin
      int exp_cnt;
      logic exp_stb;
      do_reset();
      wr(1'b1, 16'h000B);
      wr(1'b0, 16'd4);
      tick_en = 1'b1;
      exp_cnt = 0;
      for (int k = 0; k < 20; k++) begin
        step(1);
        if (exp_cnt == 4) begin exp_cnt = 0; exp_stb = 1'b1; end
        else begin exp_cnt = exp_cnt + 1; exp_stb = 1'b0; end
        chk("R9 period count", count_o, exp_cnt);
        chk("R9 strobe timing", conv_start_o, exp_stb);
      end
      tick_en = 1'b0;
    end

    // R4: a held match fires once; R2 upper bits ignored for mode.
    do_reset();
    wr(1'b1, 16'h5A0A);
    wr(1'b0, 16'd6);
    tick_en = 1'b1;
    step(6);
    chk("R4 count at match", count_o, 6);
    tick_en = 1'b0;
    step(1);
    chk("R2 mode from low bits", irq_o, 1);
    chk("R4 count held", count_o, 6);
    irq_clr = 1'b1; step(1); irq_clr = 1'b0;
    begin
      int refires;
      refires = 0;
      for (int k = 0; k < 10; k++) begin
        step(1);
        if (irq_o) refires++;
      end
      chk("R4 no retrigger", refires, 0);
    end
    wr(1'b0, 16'd7);
    wr(1'b0, 16'd6);
    irq_clr = 1'b1; step(1); irq_clr = 1'b0;
    chk("R7 set wins over clear", irq_o, 1);
    chk("R2 compare write", count_o, 6);

    // R3: natural wrap.
    do_reset();
    tick_en = 1'b1;
    step(65535);
    chk("R3 top count", count_o, 16'hFFFF);
    chk("R3 no early ovf", ovf_o, 0);
    step(1);
    chk("R3 wrap count", count_o, 0);
    chk("R3 ovf set", ovf_o, 1);
    tick_en = 1'b0;
    step(3);
    chk("R3 hold", count_o, 0);
    chk("R3 ovf sticky", ovf_o, 1);
    ovf_clr = 1'b1; step(1); ovf_clr = 1'b0;
    chk("R3 ovf cleared", ovf_o, 0);

    // R10: trigger restart at all ones does not set overflow.
    do_reset();
    wr(1'b1, 16'h000B);
    wr(1'b0, 16'hFFFF);
    tick_en = 1'b1;
    step(65535);
    chk("R10 top count", count_o, 16'hFFFF);
    step(1);
    chk("R10 restart count", count_o, 0);
    chk("R10 strobe", conv_start_o, 1);
    chk("R10 no ovf", ovf_o, 0);
    tick_en = 1'b0;

    finish_run();
  end

endmodule